// File: doc/BRIEF.md
# Shared Bus Arbiter with Lock and Host Port

This block decides which agent owns a shared external bus. Up to six processor nodes and one host compete for it. Each node has a request line and a grant line. The host has a request line, a grant line and a ready flag. A mode input selects how the nodes are ranked: fixed order, or a rotating order in which the node that last gave up the bus drops to the bottom.

A node keeps the bus for as long as it holds its request. The current master can also raise a lock input so that an indivisible read-modify-write sequence completes without interruption. When the bus changes hands, exactly one cycle passes with no grant active. When the bus is free and lock is low, the host comes before any node. The host then keeps the bus until it drops its request.

All grants come straight from registers, and the block uses one clock with a synchronous active-low reset.

Top module: `xbus_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, every node grant, `host_gnt` and `host_rdy` are low.
- R2: At most one of the node grants and `host_gnt` is high in any cycle.
- R3: With `rotate_mode` low, a free bus goes to the requesting node with the lowest index (node 0 highest, node 5 lowest). The grant appears one clock edge after the request is sampled.
- R4: With `rotate_mode` high, the search starts at the index just above the node that last released the bus and wraps from the top index back to 0, so the node that released last has the lowest priority.
- R5: A node that holds the bus keeps its grant for as long as its request stays high.
- R6: A master releases the bus at the clock edge that samples its request low while `lock` is low. One cycle with no grant follows, and the next winner is granted at the following edge.
- R7: While `lock` is high, the current node master keeps its grant even if its request drops, and a free bus is not given to the host.
- R8: When the bus is free and `lock` is low, a host request wins over every node request. The host then keeps the bus until `host_req` is sampled low.
- R9: `host_rdy` is high only while the host owns the bus. It is low in the first cycle of a host tenure and high from the second cycle on, for as long as the host keeps the bus.
- R10: A host tenure does not change the rotation point. After reset the rotation point is the top index, so node 0 ranks highest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rotate_mode | input | 1 | 0 = fixed node order, 1 = rotating node order |
| lock | input | 1 | Current master keeps the bus |
| node_req | input | NODES | Bus request, one bit per node |
| host_req | input | 1 | Host bus request |
| node_gnt | output | NODES | Bus grant, one bit per node |
| host_gnt | output | 1 | Host bus grant |
| host_rdy | output | 1 | Host access may complete |

## Verification
Some rules are checked by assertions on every cycle:
- a single active grant;
- the idle gap whenever the owner changes;
- a locked node keeping its grant;
- the host keeping the bus while it requests;
- the ready flag appearing only under a host grant;
- the rotation point staying unchanged during host tenures.

Other behaviour shows only in the bench scenarios:
- which node wins under each mode;
- the wrap-around of the rotating search;
- the host winning over waiting nodes;
- the exact cycle in which ready rises.

These are compared cycle by cycle against an independent reference model, under directed sequences and under seeded random traffic.

// File: rtl/xbus_arb_pkg.sv
// Package: shared types for the bus arbiter.
// Assumes: no more than one master kind is active at a time.
package xbus_arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_NODE = 2'd1,
        OWN_HOST = 2'd2
    } owner_e;
endpackage

// File: rtl/xbus_prio_pick.sv
// Module: picks one requesting node under fixed or rotating order.
// Assumes: last_idx < N. In fixed mode index 0 ranks highest; in rotating
// mode the ranking starts at last_idx+1 and wraps from the top index to 0.
module xbus_prio_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic          rotate,
    input  logic [IW-1:0] last_idx,
    output logic          hit,
    output logic [IW-1:0] win
);
    // Scan candidates from lowest to highest rank; the last match kept is the best.
    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int s = N; s >= 1; s--) begin
            int c;
            c = rotate ? ((int'(last_idx) + s) % N) : (s - 1);
            if (req[c]) begin
                hit = 1'b1;
                win = IW'(c);
            end
        end
    end

    // R3: in fixed mode no lower-index node may be requesting besides the winner
    always_comb begin
        if (hit && !rotate) begin
            a_r3_fixed_lowest: assert ((req & ((N'(1) << win) - N'(1))) == '0);
        end
    end
endmodule

// File: rtl/xbus_owner_ctrl.sv
// Module: bus ownership state machine.
// Assumes: release happens only from the owned state, so the state passes
// through OWN_NONE for one cycle between masters. The host wins a free bus
// when lock is low.
module xbus_owner_ctrl
    import xbus_arb_pkg::*;
#(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  node_req,
    input  logic          host_req,
    input  logic          lock,
    input  logic          pick_hit,
    input  logic [IW-1:0] pick_idx,
    output owner_e        own,
    output logic [IW-1:0] own_idx,
    output logic [IW-1:0] last_idx,
    output logic          host_stays
);
    owner_e        own_n;
    logic [IW-1:0] own_idx_n;
    logic [IW-1:0] last_idx_n;

    // Next-owner decision: claim a free bus, or release an owned one.
    always_comb begin
        own_n      = own;
        own_idx_n  = own_idx;
        last_idx_n = last_idx;
        unique case (own)
            OWN_NONE: begin
                if (host_req && !lock) begin
                    own_n = OWN_HOST;
                end else if (pick_hit) begin
                    own_n     = OWN_NODE;
                    own_idx_n = pick_idx;
                end
            end
            OWN_NODE: begin
                if (!node_req[own_idx] && !lock) begin
                    own_n      = OWN_NONE;
                    last_idx_n = own_idx;
                end
            end
            OWN_HOST: begin
                if (!host_req) begin
                    own_n = OWN_NONE;
                end
            end
            default: own_n = OWN_NONE;
        endcase
    end

    // Ownership registers with synchronous reset; rotation point starts at the top index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own      <= OWN_NONE;
            own_idx  <= '0;
            last_idx <= IW'(N - 1);
        end else begin
            own      <= own_n;
            own_idx  <= own_idx_n;
            last_idx <= last_idx_n;
        end
    end

    // Host keeps the bus into the next cycle.
    assign host_stays = (own == OWN_HOST) && host_req;

    // R7: a locked node owner keeps the bus
    a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (own == OWN_NODE && lock) |=> (own == OWN_NODE && own_idx == $past(own_idx)));

    // R8: the host keeps the bus while it requests
    a_r8_host_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (own == OWN_HOST && host_req) |=> (own == OWN_HOST));

    // R10: a host tenure leaves the rotation point alone
    a_r10_ptr_host: assert property (@(posedge clk) disable iff (!rst_n)
        (own == OWN_HOST) |=> $stable(last_idx));
endmodule

// File: rtl/xbus_grant_out.sv
// Module: decodes ownership into grant lines and registers the host ready flag.
// Assumes: own/own_idx are registers, so the grants come from flops.
module xbus_grant_out
    import xbus_arb_pkg::*;
#(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  owner_e        own,
    input  logic [IW-1:0] own_idx,
    input  logic          host_stays,
    output logic [N-1:0]  node_gnt,
    output logic          host_gnt,
    output logic          host_rdy
);
    // One decoded grant per node.
    for (genvar g = 0; g < N; g++) begin : g_gnt
        assign node_gnt[g] = (own == OWN_NODE) && (own_idx == IW'(g));
    end

    assign host_gnt = (own == OWN_HOST);

    // Ready rises one cycle into a host tenure and stays while the host holds the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdy <= 1'b0;
        else        host_rdy <= host_stays;
    end

    // R9: ready only under a host grant
    a_r9_rdy_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |-> host_gnt);
endmodule

// File: rtl/xbus_arbiter.sv
// Module: top of the shared bus arbiter (nodes plus one host, lock, idle changeover).
// Assumes: one clock, synchronous active-low reset, and inputs synchronous to clk.
module xbus_arbiter
    import xbus_arb_pkg::*;
#(
    parameter int NODES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rotate_mode,
    input  logic             lock,
    input  logic [NODES-1:0] node_req,
    input  logic             host_req,
    output logic [NODES-1:0] node_gnt,
    output logic             host_gnt,
    output logic             host_rdy
);
    localparam int IW = (NODES > 1) ? $clog2(NODES) : 1;

    owner_e        own;
    logic [IW-1:0] own_idx;
    logic [IW-1:0] last_idx;
    logic          pick_hit;
    logic [IW-1:0] pick_idx;
    logic          host_stays;

    xbus_prio_pick #(.N(NODES), .IW(IW)) u_pick (
        .req      (node_req),
        .rotate   (rotate_mode),
        .last_idx (last_idx),
        .hit      (pick_hit),
        .win      (pick_idx)
    );

    xbus_owner_ctrl #(.N(NODES), .IW(IW)) u_owner (
        .clk        (clk),
        .rst_n      (rst_n),
        .node_req   (node_req),
        .host_req   (host_req),
        .lock       (lock),
        .pick_hit   (pick_hit),
        .pick_idx   (pick_idx),
        .own        (own),
        .own_idx    (own_idx),
        .last_idx   (last_idx),
        .host_stays (host_stays)
    );

    xbus_grant_out #(.N(NODES), .IW(IW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .own        (own),
        .own_idx    (own_idx),
        .host_stays (host_stays),
        .node_gnt   (node_gnt),
        .host_gnt   (host_gnt),
        .host_rdy   (host_rdy)
    );

    // R2: never more than one grant
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_gnt, node_gnt}));

    // R6: a grant is either kept or followed by an empty cycle
    a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((|node_gnt) || host_gnt) |=>
            (({host_gnt, node_gnt} == $past({host_gnt, node_gnt})) ||
             ({host_gnt, node_gnt} == '0)));
endmodule

// File: tb/tb_xbus_arbiter.sv
module tb_xbus_arbiter;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rotate_mode = 1'b0;
    logic         lock = 1'b0;
    logic [N-1:0] node_req = '0;
    logic         host_req = 1'b0;
    logic [N-1:0] node_gnt;
    logic         host_gnt;
    logic         host_rdy;

    int checks = 0;
    int fails  = 0;

    // Reference model state: 0 none, 1 node, 2 host
    int m_own = 0;
    int m_idx = 0;
    int m_last = N - 1;
    bit m_rdy = 1'b0;

    always #4 clk = ~clk;

    xbus_arbiter #(.NODES(N)) dut (
        .clk(clk), .rst_n(rst_n), .rotate_mode(rotate_mode), .lock(lock),
        .node_req(node_req), .host_req(host_req),
        .node_gnt(node_gnt), .host_gnt(host_gnt), .host_rdy(host_rdy)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference pick: -1 when nobody requests
    function automatic int ref_pick(logic [N-1:0] r, bit rot, int last);
        if (!rot) begin
            for (int i = 0; i < N; i++) if (r[i]) return i;
        end else begin
            for (int s = 1; s <= N; s++) begin
                int j;
                j = (last + s) % N;
                if (r[j]) return j;
            end
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] ref_gnt(int own, int idx);
        return (own == 1) ? (N'(1) << idx) : '0;
    endfunction

    // One clock: advance the model with the current inputs, then compare after the edge
    task automatic cyc();
        int nown, nidx, nlast, p;
        bit nrdy;
        string tag;
        nown = m_own; nidx = m_idx; nlast = m_last; tag = "R5";
        if (m_own == 0) begin
            p = ref_pick(node_req, rotate_mode, m_last);
            if (host_req && !lock) begin nown = 2; tag = "R8"; end
            else if (p >= 0) begin nown = 1; nidx = p; tag = rotate_mode ? "R4" : "R3"; end
            else if (host_req) tag = "R7";
        end else if (m_own == 1) begin
            if (lock) tag = "R7";
            else if (!node_req[m_idx]) begin nown = 0; nlast = m_idx; tag = "R6"; end
        end else begin
            tag = "R8";
            if (!host_req) begin nown = 0; tag = "R6"; end
        end
        nrdy = (m_own == 2) && (nown == 2);
        @(posedge clk);
        m_own = nown; m_idx = nidx; m_last = nlast; m_rdy = nrdy;
        #2;
        check(tag, 32'(node_gnt), 32'(ref_gnt(m_own, m_idx)));
        check(tag, 32'(host_gnt), 32'(m_own == 2));
        check("R9", 32'(host_rdy), 32'(m_rdy));
        check("R2", 32'($countones({host_gnt, node_gnt}) <= 1), 32'd1);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        rst_n = 1'b0;
        node_req = 6'b111111; host_req = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1", 32'(node_gnt), 32'd0);
        check("R1", 32'(host_gnt), 32'd0);
        check("R1", 32'(host_rdy), 32'd0);
        node_req = '0; host_req = 1'b0;
        rst_n = 1'b1;
        m_own = 0; m_idx = 0; m_last = N - 1; m_rdy = 0;
        cyc();
        check("R1", 32'(node_gnt), 32'd0);

        // R3: fixed order, lowest index wins
        node_req = 6'b110100;
        cyc();
        check("R3", 32'(node_gnt), 32'h04);
        cyc();
        check("R5", 32'(node_gnt), 32'h04);
        // R6: release gives one idle cycle then the next winner
        node_req = 6'b110000;
        cyc();
        check("R6", 32'(node_gnt), 32'h00);
        cyc();
        check("R6", 32'(node_gnt), 32'h10);
        // R7: lock holds the bus and keeps the host out
        lock = 1'b1; node_req = 6'b100000; host_req = 1'b1;
        repeat (3) begin
            cyc();
            check("R7", 32'(node_gnt), 32'h10);
            check("R7", 32'(host_gnt), 32'd0);
        end
        lock = 1'b0;
        cyc();
        check("R6", 32'(node_gnt), 32'h00);
        // R8: host beats a waiting node
        cyc();
        check("R8", 32'(host_gnt), 32'd1);
        check("R9", 32'(host_rdy), 32'd0);
        cyc();
        check("R9", 32'(host_rdy), 32'd1);
        host_req = 1'b0;
        cyc();
        check("R8", 32'(host_gnt), 32'd0);
        check("R9", 32'(host_rdy), 32'd0);
        cyc();
        check("R8", 32'(node_gnt), 32'h20);
        // R4: rotating order wraps after node 5
        rotate_mode = 1'b1;
        node_req = 6'b001001;
        cyc();
        cyc();
        check("R4", 32'(node_gnt), 32'h01);
        node_req = 6'b001000;
        cyc();
        node_req = 6'b001001;
        cyc();
        check("R4", 32'(node_gnt), 32'h08);
        // R10: host tenure leaves the rotation point at node 3
        node_req = 6'b000001; host_req = 1'b1;
        cyc();
        cyc();
        check("R10", 32'(host_gnt), 32'd1);
        host_req = 1'b0; node_req = 6'b010001;
        cyc();
        cyc();
        check("R10", 32'(node_gnt), 32'h10);

        // Seeded random traffic against the model
        node_req = '0;
        cyc(); cyc();
        for (int k = 0; k < 4000; k++) begin
            if (k % 500 == 0) rotate_mode = $urandom_range(0, 1) == 1;
            for (int b = 0; b < N; b++)
                if ($urandom_range(0, 9) == 0) node_req[b] = ~node_req[b];
            if ($urandom_range(0, 19) == 0) host_req = ~host_req;
            lock = ($urandom_range(0, 7) == 0) ? ~lock : lock;
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule